// File: doc/BRIEF.md
# PCI Configuration Access Cycle Translator

This block turns host accesses to an indirect configuration register pair, and to a separate interrupt-acknowledge read port, into single-data-phase PCI master transactions. The host first loads a 32-bit configuration address word. Each later access to the configuration data port then chooses one of four transactions: a type 0 configuration cycle, a type 1 configuration cycle, a special cycle or an interrupt acknowledge. The choice depends on the latched address word, on the controller's own bus number and on the access direction.

For each accepted access the block drives one address phase and then a data phase. In each phase it presents the AD value and the command or byte-enable nibble, and it produces even parity over both one clock later. The data phase is held until the target signals ready or the engine reports a master-abort. Read data is returned when the cycle completes. A sticky received-master-abort flag records aborts, but a special cycle, which always ends in master-abort, leaves that flag alone.

Top module: `pci_cfg_xlate`

## Requirements
- R1: A data-port access is accepted only when bit 31 (enable) of the latched address word is 1. With enable 0 a data-port access launches no cycle: busy, addr_phase and data_phase stay 0.
- R2: Address word fields are bus = [23:16], device = [15:11], function = [10:8] and register = [7:2]. If bus equals own_bus, device is 31, function is 7 and register is 0, a data-port write launches a special cycle. That cycle uses command 4'b0001, address-phase AD of 0 and byte enables 4'b0000. Its data-phase AD is the written word unchanged: the message code in [15:0], which may be any value 0x0000 to 0xFFFF including reserved codes, and the message data in [31:16].
- R3: With the same special pattern latched, a data-port read launches an interrupt acknowledge. It uses command 4'b0000, address-phase AD of 0, and the host's byte enables in the data phase. On a normal finish rd_value holds the bus_rdata value present on the clock in which bus_trdy was 1.
- R4: An iack_req launches an interrupt acknowledge (command 4'b0000, byte enables iack_be) whatever the address word holds, including when the enable bit is clear.
- R5: When bus differs from own_bus, a data-port access becomes a type 1 configuration cycle. The address-phase AD is {8'h00, word[23:2], 2'b01}, and the command is 4'b1010 for a read or 4'b1011 for a write.
- R6: When bus equals own_bus and the pattern is not special, the access becomes a type 0 configuration cycle. AD[31:11] has only bit 11+device set when device is 20 or less and is all zero otherwise; AD[10:8] = function, AD[7:2] = register and AD[1:0] = 00. The commands are the same as in R5.
- R7: In a configuration cycle the data phase carries the host byte enables. For a write, the data-phase AD carries the written word; for a read, the data-phase AD is 0.
- R8: A master-abort sets rma_status on any cycle other than a special cycle, and rma_status then stays set until rma_clr. A master-abort on a special cycle leaves rma_status unchanged. A master-aborted read returns 32'hFFFFFFFF on rd_value.
- R9: In the clock after each address-phase or data-phase clock, par_valid is 1 and par_out equals the XOR of the 32 AD bits and 4 command/byte-enable bits of that phase clock.
- R10: addr_phase lasts exactly one clock, starting the clock after acceptance. data_phase follows it and holds AD and byte enables stable until bus_trdy or bus_mabort. done pulses for one clock after the data phase, with busy already 0. Accesses that arrive while busy is 1 are dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| own_bus | input | 8 | Bus number of this controller |
| cfga_we | input | 1 | Write strobe for the configuration address word |
| cfga_wdata | input | 32 | Configuration address word value |
| cfgd_req | input | 1 | Access to the configuration data port |
| cfgd_write | input | 1 | 1 = data-port write, 0 = data-port read |
| cfgd_wdata | input | 32 | Data-port write value |
| cfgd_be | input | 4 | Data-port byte enables |
| iack_req | input | 1 | Read of the interrupt-acknowledge port |
| iack_be | input | 4 | Byte enables for that read |
| bus_trdy | input | 1 | Target ready in the data phase |
| bus_mabort | input | 1 | Master-abort termination of the data phase |
| bus_rdata | input | 32 | Data returned by the target |
| rma_clr | input | 1 | Clears the received-master-abort flag |
| busy | output | 1 | A cycle is in progress |
| addr_phase | output | 1 | Address phase clock |
| data_phase | output | 1 | Data phase clock |
| ad_out | output | 32 | AD value driven in the current phase |
| cbe_out | output | 4 | Command (address phase) or byte enables (data phase) |
| par_out | output | 1 | Even parity of the previous phase |
| par_valid | output | 1 | par_out refers to a phase |
| done | output | 1 | Cycle finished pulse |
| rd_value | output | 32 | Read result |
| rma_status | output | 1 | Sticky received-master-abort flag |

## Verification
The bench sweeps every device number 0 to 31 against every function number, with the bus both matching and differing from own_bus, in both directions. This sweep separates type 0 from type 1 formatting and shows where the one-hot select stops at device 20. The varied wait states and aborts in the same sweep expose phase holding, read capture, abort read data and flag setting. Special-cycle writes are repeated over the low defined message codes, reserved codes and 0xFFFF, with aborts, to confirm that data passes through unchanged and that the flag stays clear. Special-pattern reads, interrupt-acknowledge port reads with enable clear, enable-clear data-port accesses, a near-miss pattern on a foreign bus and a request issued while busy each isolate one decode rule.

// File: rtl/pci_xlate_pkg.sv
package pci_xlate_pkg;
  localparam int AD_W  = 32;
  localparam int CBE_W = AD_W / 8;

  localparam logic [CBE_W-1:0] CMD_IACK    = 4'b0000;
  localparam logic [CBE_W-1:0] CMD_SPECIAL = 4'b0001;
  localparam logic [CBE_W-1:0] CMD_CFG_RD  = 4'b1010;
  localparam logic [CBE_W-1:0] CMD_CFG_WR  = 4'b1011;

  typedef enum logic [1:0] {CYC_IACK, CYC_SPECIAL, CYC_TYPE0, CYC_TYPE1} cyc_kind_e;

  typedef struct packed {
    cyc_kind_e        kind;
    logic             is_read;
    logic [CBE_W-1:0] cmd;
    logic [AD_W-1:0]  addr_ad;
    logic [AD_W-1:0]  data_ad;
    logic [CBE_W-1:0] be;
  } cyc_desc_t;
endpackage

// File: rtl/pci_xlate_decode.sv
module pci_xlate_decode
  import pci_xlate_pkg::*;
#(
  parameter int EN_BIT  = 31,
  parameter int BUS_LSB = 16,
  parameter int BUS_W   = 8,
  parameter int DEV_LSB = 11,
  parameter int DEV_W   = 5,
  parameter int FUN_LSB = 8,
  parameter int FUN_W   = 3,
  parameter int REG_LSB = 2,
  parameter int REG_W   = 6
) (
  input  logic [AD_W-1:0]  cfg_addr,
  input  logic [BUS_W-1:0] own_bus,
  input  logic             cfgd_req,
  input  logic             cfgd_write,
  input  logic [AD_W-1:0]  cfgd_wdata,
  input  logic [CBE_W-1:0] cfgd_be,
  input  logic             iack_req,
  input  logic [CBE_W-1:0] iack_be,
  output logic             launch,
  output cyc_desc_t        desc
);
  localparam int SEL_N   = AD_W - DEV_LSB;
  localparam int T1_HI   = BUS_LSB + BUS_W - 1;
  localparam int T1_PAD  = AD_W - 1 - T1_HI;

  logic [BUS_W-1:0] f_bus;
  logic [DEV_W-1:0] f_dev;
  logic [FUN_W-1:0] f_fun;
  logic [REG_W-1:0] f_reg;
  logic [SEL_N-1:0] idsel;
  logic             bus_hit, special_pat, data_go;
  logic [AD_W-1:0]  type0_ad, type1_ad;

  assign f_bus = cfg_addr[BUS_LSB +: BUS_W];
  assign f_dev = cfg_addr[DEV_LSB +: DEV_W];
  assign f_fun = cfg_addr[FUN_LSB +: FUN_W];
  assign f_reg = cfg_addr[REG_LSB +: REG_W];

  generate
    for (genvar i = 0; i < SEL_N; i++) begin : g_idsel
      assign idsel[i] = (f_dev == DEV_W'(i));
    end
  endgenerate

  assign bus_hit     = (f_bus == own_bus);
  assign special_pat = bus_hit && (&f_dev) && (&f_fun) && (f_reg == '0);
  assign data_go     = cfgd_req && cfg_addr[EN_BIT];
  assign launch      = data_go || iack_req;
  assign type0_ad    = {idsel, f_fun, f_reg, 2'b00};
  assign type1_ad    = {{T1_PAD{1'b0}}, cfg_addr[T1_HI:REG_LSB], 2'b01};

  always_comb begin
    desc = '0;
    if (data_go) begin
      desc.is_read = !cfgd_write;
      desc.be      = cfgd_be;
      if (special_pat) begin
        if (cfgd_write) begin
          desc.kind    = CYC_SPECIAL;
          desc.cmd     = CMD_SPECIAL;
          desc.data_ad = cfgd_wdata;
          desc.be      = '0;
        end else begin
          desc.kind = CYC_IACK;
          desc.cmd  = CMD_IACK;
        end
      end else begin
        desc.kind    = bus_hit ? CYC_TYPE0 : CYC_TYPE1;
        desc.cmd     = cfgd_write ? CMD_CFG_WR : CMD_CFG_RD;
        desc.addr_ad = bus_hit ? type0_ad : type1_ad;
        desc.data_ad = cfgd_write ? cfgd_wdata : '0;
      end
    end else begin
      desc.kind    = CYC_IACK;
      desc.cmd     = CMD_IACK;
      desc.is_read = 1'b1;
      desc.be      = iack_be;
    end
  end
endmodule

// File: rtl/pci_xlate_seq.sv
module pci_xlate_seq
  import pci_xlate_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             launch,
  input  cyc_desc_t        desc,
  input  logic             bus_trdy,
  input  logic             bus_mabort,
  input  logic [AD_W-1:0]  bus_rdata,
  input  logic             rma_clr,
  output logic             busy,
  output logic             addr_phase,
  output logic             data_phase,
  output logic [AD_W-1:0]  ad_out,
  output logic [CBE_W-1:0] cbe_out,
  output logic             done,
  output logic [AD_W-1:0]  rd_value,
  output logic             rma_status
);
  typedef enum logic [1:0] {S_IDLE, S_ADDR, S_DATA} st_e;

  st_e             st_q, st_n;
  cyc_desc_t       desc_q;
  logic            desc_ld, done_n, rma_n;
  logic [AD_W-1:0] rd_n;

  always_comb begin
    st_n    = st_q;
    desc_ld = 1'b0;
    done_n  = 1'b0;
    rd_n    = rd_value;
    rma_n   = rma_clr ? 1'b0 : rma_status;
    case (st_q)
      S_IDLE: if (launch) begin
        st_n    = S_ADDR;
        desc_ld = 1'b1;
      end
      S_ADDR: st_n = S_DATA;
      S_DATA: if (bus_mabort || bus_trdy) begin
        st_n   = S_IDLE;
        done_n = 1'b1;
        if (bus_mabort) begin
          if (desc_q.is_read) rd_n = '1;
          if (desc_q.kind != CYC_SPECIAL) rma_n = 1'b1;
        end else if (desc_q.is_read) begin
          rd_n = bus_rdata;
        end
      end
      default: st_n = S_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q       <= S_IDLE;
      done       <= 1'b0;
      rd_value   <= '0;
      rma_status <= 1'b0;
      desc_q     <= '0;
    end else begin
      st_q       <= st_n;
      done       <= done_n;
      rd_value   <= rd_n;
      rma_status <= rma_n;
      if (desc_ld) desc_q <= desc;
    end
  end

  assign busy       = (st_q != S_IDLE);
  assign addr_phase = (st_q == S_ADDR);
  assign data_phase = (st_q == S_DATA);
  assign ad_out     = addr_phase ? desc_q.addr_ad : (data_phase ? desc_q.data_ad : '0);
  assign cbe_out    = addr_phase ? desc_q.cmd     : (data_phase ? desc_q.be      : '0);
endmodule

// File: rtl/pci_xlate_parity.sv
module pci_xlate_parity
  import pci_xlate_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic [AD_W-1:0]  ad,
  input  logic [CBE_W-1:0] cbe,
  input  logic             phase_on,
  output logic             par_out,
  output logic             par_valid
);
  logic par_n;

  always_comb par_n = ^{ad, cbe};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      par_out   <= 1'b0;
      par_valid <= 1'b0;
    end else begin
      par_out   <= par_n;
      par_valid <= phase_on;
    end
  end
endmodule

// File: rtl/pci_cfg_xlate.sv
module pci_cfg_xlate
  import pci_xlate_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic [7:0]  own_bus,
  input  logic        cfga_we,
  input  logic [31:0] cfga_wdata,
  input  logic        cfgd_req,
  input  logic        cfgd_write,
  input  logic [31:0] cfgd_wdata,
  input  logic [3:0]  cfgd_be,
  input  logic        iack_req,
  input  logic [3:0]  iack_be,
  input  logic        bus_trdy,
  input  logic        bus_mabort,
  input  logic [31:0] bus_rdata,
  input  logic        rma_clr,
  output logic        busy,
  output logic        addr_phase,
  output logic        data_phase,
  output logic [31:0] ad_out,
  output logic [3:0]  cbe_out,
  output logic        par_out,
  output logic        par_valid,
  output logic        done,
  output logic [31:0] rd_value,
  output logic        rma_status
);
  logic [1:0]      rst_pipe;
  logic            rst_core_n;
  logic [AD_W-1:0] cfg_addr_q;
  logic            launch;
  cyc_desc_t       desc;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= 2'b00;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_core_n = rst_pipe[1];

  always_ff @(posedge clk or negedge rst_core_n) begin
    if (!rst_core_n)  cfg_addr_q <= '0;
    else if (cfga_we) cfg_addr_q <= cfga_wdata;
  end

  pci_xlate_decode u_dec (
    .cfg_addr(cfg_addr_q), .own_bus(own_bus),
    .cfgd_req(cfgd_req), .cfgd_write(cfgd_write), .cfgd_wdata(cfgd_wdata),
    .cfgd_be(cfgd_be), .iack_req(iack_req), .iack_be(iack_be),
    .launch(launch), .desc(desc)
  );

  pci_xlate_seq u_seq (
    .clk(clk), .rst_n(rst_core_n), .launch(launch), .desc(desc),
    .bus_trdy(bus_trdy), .bus_mabort(bus_mabort), .bus_rdata(bus_rdata),
    .rma_clr(rma_clr), .busy(busy), .addr_phase(addr_phase),
    .data_phase(data_phase), .ad_out(ad_out), .cbe_out(cbe_out),
    .done(done), .rd_value(rd_value), .rma_status(rma_status)
  );

  pci_xlate_parity u_par (
    .clk(clk), .rst_n(rst_core_n), .ad(ad_out), .cbe(cbe_out),
    .phase_on(addr_phase || data_phase),
    .par_out(par_out), .par_valid(par_valid)
  );
endmodule

// File: rtl/pci_cfg_xlate_chk.sv
module pci_cfg_xlate_chk
  import pci_xlate_pkg::*;
(
  input logic        clk,
  input logic        rst_n,
  input logic        bus_trdy,
  input logic        bus_mabort,
  input logic        rma_clr,
  input logic        busy,
  input logic        addr_phase,
  input logic        data_phase,
  input logic [31:0] ad_out,
  input logic [3:0]  cbe_out,
  input logic        par_valid,
  input logic        done,
  input logic        rma_status
);
  logic cur_special;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          cur_special <= 1'b0;
    else if (addr_phase) cur_special <= (cbe_out == CMD_SPECIAL);
  end

  // R10
  addr_then_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
    addr_phase |=> data_phase);

  // R10
  data_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    data_phase && !bus_trdy && !bus_mabort |=> data_phase && $stable(ad_out) && $stable(cbe_out));

  // R10
  finish_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    data_phase && (bus_trdy || bus_mabort) |=> done && !busy);

  // R10
  phase_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({addr_phase, data_phase, done}));

  // R2
  legal_cmd_chk: assert property (@(posedge clk) disable iff (!rst_n)
    addr_phase |-> (cbe_out == CMD_IACK || cbe_out == CMD_SPECIAL ||
                    cbe_out == CMD_CFG_RD || cbe_out == CMD_CFG_WR));

  // R8
  special_no_rma_chk: assert property (@(posedge clk) disable iff (!rst_n)
    data_phase && bus_mabort && cur_special && !rma_status |=> !rma_status);

  // R8
  abort_sets_rma_chk: assert property (@(posedge clk) disable iff (!rst_n)
    data_phase && bus_mabort && !cur_special |=> rma_status);

  // R9
  par_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (addr_phase || data_phase) |=> par_valid);
endmodule

bind pci_cfg_xlate pci_cfg_xlate_chk u_chk (.*);

// File: tb/pci_cfg_xlate_test.sv
module pci_cfg_xlate_test;
  localparam int CLK_P = 10;
  localparam logic [7:0] OWN = 8'h3C;

  logic        clk, rst_n;
  logic [7:0]  own_bus;
  logic        cfga_we, cfgd_req, cfgd_write, iack_req, bus_trdy, bus_mabort, rma_clr;
  logic [31:0] cfga_wdata, cfgd_wdata, bus_rdata;
  logic [3:0]  cfgd_be, iack_be;
  logic        busy, addr_phase, data_phase, par_out, par_valid, done, rma_status;
  logic [31:0] ad_out, rd_value;
  logic [3:0]  cbe_out;

  int checks = 0, fails = 0;

  // captured per cycle
  logic        g_aph, g_dph, g_apv, g_apar, g_dpar, g_done, g_busy, g_stable;
  logic [31:0] g_aad, g_dad, g_rd;
  logic [3:0]  g_acbe, g_dcbe;

  pci_cfg_xlate uut (.*);

  initial clk = 1'b0;
  always #(CLK_P/2) clk = ~clk;

  initial begin
    #(CLK_P * 190000);
    checks++; fails++;
    $display("FAIL watchdog R10 act=hung exp=finish");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic set_addr(input logic [31:0] v);
    @(negedge clk); cfga_we = 1'b1; cfga_wdata = v;
    @(negedge clk); cfga_we = 1'b0;
  endtask

  task automatic pulse_clr();
    @(negedge clk); rma_clr = 1'b1;
    @(negedge clk); rma_clr = 1'b0;
  endtask

  task automatic run(input bit use_iack, input bit wr, input logic [31:0] wd,
                     input logic [3:0] be, input int waits, input bit abort,
                     input logic [31:0] rdata);
    @(negedge clk);
    if (use_iack) begin iack_req = 1'b1; iack_be = be; end
    else begin cfgd_req = 1'b1; cfgd_write = wr; cfgd_wdata = wd; cfgd_be = be; end
    @(negedge clk);
    iack_req = 1'b0; cfgd_req = 1'b0;
    g_aph = addr_phase; g_aad = ad_out; g_acbe = cbe_out;
    @(negedge clk);
    g_dph = data_phase; g_dad = ad_out; g_dcbe = cbe_out;
    g_apar = par_out; g_apv = par_valid; g_stable = 1'b1;
    for (int w = 0; w < waits; w++) begin
      @(negedge clk);
      g_stable &= data_phase && (ad_out == g_dad) && (cbe_out == g_dcbe);
    end
    if (abort) bus_mabort = 1'b1; else bus_trdy = 1'b1;
    bus_rdata = rdata;
    @(negedge clk);
    bus_mabort = 1'b0; bus_trdy = 1'b0; bus_rdata = 32'h0;
    g_done = done; g_rd = rd_value; g_dpar = par_out; g_busy = busy;
  endtask

  function automatic logic par36(input logic [31:0] a, input logic [3:0] c);
    return ^{a, c};
  endfunction

  function automatic logic [31:0] exp_cfg_ad(input bit hit, input logic [31:0] w);
    int dev, fun, rg;
    logic [31:0] r;
    dev = int'(w[15:11]); fun = int'(w[10:8]); rg = int'(w[7:2]);
    if (hit) begin
      r = (dev <= 20) ? (32'h1 << (11 + dev)) : 32'h0;
      r = r + 32'(fun * 256) + 32'(rg * 4);
    end else begin
      r = (w & 32'h00FF_FFFC) + 32'h1;
    end
    return r;
  endfunction

  initial begin
    rst_n = 1'b0; own_bus = OWN;
    cfga_we = 0; cfga_wdata = 0; cfgd_req = 0; cfgd_write = 0; cfgd_wdata = 0; cfgd_be = 0;
    iack_req = 0; iack_be = 0; bus_trdy = 0; bus_mabort = 0; bus_rdata = 0; rma_clr = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // reset state
    chk(!busy && !addr_phase && !data_phase && !done, "R10 reset idle", {28'h0, busy, addr_phase, data_phase, done}, 32'h0);
    chk(!rma_status && !par_valid, "R8 reset flag", {30'h0, rma_status, par_valid}, 32'h0);

    // R1: enable clear, data port accesses ignored
    set_addr(32'h0000_0000 | (32'(OWN) << 16));
    for (int rw = 0; rw < 2; rw++) begin
      @(negedge clk); cfgd_req = 1'b1; cfgd_write = rw[0]; cfgd_wdata = 32'h1234_5678;
      @(negedge clk); cfgd_req = 1'b0;
      chk(!busy && !addr_phase, "R1 no launch", {30'h0, busy, addr_phase}, 32'h0);
      @(negedge clk);
      chk(!busy && !data_phase && !par_valid, "R1 still idle", {29'h0, busy, data_phase, par_valid}, 32'h0);
    end

    // R4: interrupt-acknowledge port with enable clear
    run(1'b1, 1'b0, 32'h0, 4'b0110, 1, 1'b0, 32'hCAFE_0042);
    chk(g_aph && g_acbe == 4'b0000, "R4 iack cmd", {27'h0, g_aph, g_acbe}, 32'h10);
    chk(g_dcbe == 4'b0110, "R4 iack be", {28'h0, g_dcbe}, 32'h6);
    chk(g_done && g_rd == 32'hCAFE_0042, "R4 iack vector", g_rd, 32'hCAFE_0042);

    // R5/R6/R7/R8/R9/R10 sweep
    for (int dev = 0; dev < 32; dev++)
      for (int fun = 0; fun < 8; fun++)
        for (int hit = 0; hit < 2; hit++)
          for (int rw = 0; rw < 2; rw++) begin
            logic [31:0] w, wd, rdata, ea, ed;
            logic [7:0]  bus;
            logic [3:0]  be, ecmd;
            int rg, waits;
            bit ab;
            rg    = (dev * 5 + fun * 3) % 64;
            bus   = hit ? OWN : (OWN ^ 8'h5A);
            w     = 32'h8000_0000 | (32'(bus) << 16) | 32'(dev << 11) | 32'(fun << 8) | 32'(rg << 2);
            wd    = 32'hA500_0000 ^ 32'(dev << 16) ^ 32'(fun * 7 + hit);
            be    = 4'((dev + fun) % 16);
            waits = (dev + fun + rw) % 3;
            ab    = (fun == 5);
            rdata = 32'h3300_0000 + 32'(dev * 256 + fun);
            set_addr(w);
            run(1'b0, rw[0], wd, be, waits, ab, rdata);
            ea   = exp_cfg_ad(hit[0], w);
            ecmd = rw[0] ? 4'b1011 : 4'b1010;
            ed   = rw[0] ? wd : 32'h0;
            if (hit[0]) chk(g_aad == ea, "R6 type0 addr", g_aad, ea);
            else        chk(g_aad == ea, "R5 type1 addr", g_aad, ea);
            chk(g_aph && g_acbe == ecmd, "R5 cfg cmd", {27'h0, g_aph, g_acbe}, {27'h0, 1'b1, ecmd});
            chk(g_dph && g_dad == ed && g_dcbe == be, "R7 data phase", g_dad ^ {28'h0, g_dcbe}, ed ^ {28'h0, be});
            chk(g_apv && g_apar == par36(ea, ecmd), "R9 addr parity", {31'h0, g_apar}, {31'h0, par36(ea, ecmd)});
            chk(g_dpar == par36(ed, be), "R9 data parity", {31'h0, g_dpar}, {31'h0, par36(ed, be)});
            chk(g_stable && g_done && !g_busy, "R10 hold and done", {29'h0, g_stable, g_done, g_busy}, 32'h6);
            if (!rw[0]) chk(g_rd == (ab ? 32'hFFFF_FFFF : rdata), "R8 read value", g_rd, ab ? 32'hFFFF_FFFF : rdata);
            if (ab) begin
              chk(rma_status, "R8 abort flag", {31'h0, rma_status}, 32'h1);
              pulse_clr();
              chk(!rma_status, "R8 flag clear", {31'h0, rma_status}, 32'h0);
            end else begin
              chk(!rma_status, "R8 no abort", {31'h0, rma_status}, 32'h0);
            end
          end

    // R2: special cycles with defined and reserved codes
    set_addr(32'h8000_0000 | (32'(OWN) << 16) | 32'h0000_FF00);
    for (int k = 0; k < 8; k++) begin
      logic [15:0] code;
      logic [31:0] v;
      code = (k < 3) ? 16'(k) : ((k == 7) ? 16'hFFFF : 16'(k * 16'h2468));
      v = {16'(16'h0F0F + k * 16'h1111), code};
      run(1'b0, 1'b1, v, 4'b1111, k % 2, 1'b1, 32'h0);
      chk(g_aph && g_acbe == 4'b0001 && g_aad == 32'h0, "R2 special addr", g_aad ^ {28'h0, g_acbe}, 32'h1);
      chk(g_dad == v && g_dcbe == 4'b0000, "R2 special data", g_dad, v);
      chk(g_apar == par36(32'h0, 4'b0001) && g_dpar == par36(v, 4'b0000), "R9 special parity", {30'h0, g_apar, g_dpar}, {30'h0, par36(32'h0, 4'b0001), par36(v, 4'b0000)});
      chk(g_done && !rma_status, "R8 special abort no flag", {30'h0, g_done, rma_status}, 32'h2);
    end

    // R3: special pattern read gives interrupt acknowledge
    for (int k = 0; k < 4; k++) begin
      logic [3:0] be;
      be = 4'(1 << k);
      run(1'b0, 1'b0, 32'hDEAD_BEEF, be, k, 1'b0, 32'h0000_0040 + 32'(k));
      chk(g_aph && g_acbe == 4'b0000 && g_aad == 32'h0, "R3 iack addr", g_aad ^ {28'h0, g_acbe}, 32'h0);
      chk(g_dcbe == be && g_dad == 32'h0, "R3 iack be", {28'h0, g_dcbe}, {28'h0, be});
      chk(g_rd == 32'h0000_0040 + 32'(k), "R3 vector", g_rd, 32'h0000_0040 + 32'(k));
    end
    run(1'b0, 1'b0, 32'h0, 4'hF, 0, 1'b1, 32'h0);
    chk(rma_status && g_rd == 32'hFFFF_FFFF, "R8 iack abort", g_rd, 32'hFFFF_FFFF);
    pulse_clr();

    // R5: special pattern on foreign bus stays a type 1 write
    set_addr(32'h8000_0000 | (32'(OWN ^ 8'h01) << 16) | 32'h0000_FF00);
    run(1'b0, 1'b1, 32'h0000_0001, 4'hF, 0, 1'b0, 32'h0);
    chk(g_acbe == 4'b1011 && g_aad == ((32'(OWN ^ 8'h01) << 16) | 32'h0000_FF01), "R5 foreign special", g_aad, (32'(OWN ^ 8'h01) << 16) | 32'h0000_FF01);

    // R10: access during busy dropped
    set_addr(32'h8000_0000 | (32'(OWN) << 16) | 32'h0000_0800);
    @(negedge clk); cfgd_req = 1'b1; cfgd_write = 1'b1; cfgd_wdata = 32'h1; cfgd_be = 4'hF;
    @(negedge clk); cfgd_req = 1'b1; cfgd_wdata = 32'h2;
    @(negedge clk); cfgd_req = 1'b0; bus_trdy = 1'b1;
    chk(data_phase && ad_out == 32'h1, "R10 first kept", ad_out, 32'h1);
    @(negedge clk); bus_trdy = 1'b0;
    chk(done, "R10 done", {31'h0, done}, 32'h1);
    @(negedge clk);
    chk(!busy && !addr_phase, "R10 busy request dropped", {30'h0, busy, addr_phase}, 32'h0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule